// File: doc/BRIEF.md
# Parallel RGB to 7:1 LVDS Lane Serializer

The block turns a stream of parallel pixels (8-bit red, green and blue plus horizontal sync, vertical sync and data enable) into the bit streams of a 7:1 serial display link. Each pixel becomes one frame of seven slots. The frame goes out on three or four data lanes, next to a lane clock that has one period per frame. The block runs entirely on the 7x bit clock, which comes from outside. Pixels enter through a valid/ready handshake into a one-entry holding register. At every frame boundary the serializers reload from that register, so frames follow one another with no gap.

A static map selector picks one of three colour-to-slot layouts. The first is an 18-bit layout on three lanes, which sends the six upper bits of each colour. The other two are 24-bit layouts on four lanes: one puts the six upper colour bits on lanes 0 to 2, the other puts the six lower colour bits there. A mirror input reverses the slot order on every data lane. Both configuration inputs may change only while reset is held. All lane outputs are modelled as single-ended logic.

Back-pressure rule: a pixel is taken on a cycle where `pix_valid` and `pix_ready` are both high. `pix_ready` is high when the holding register is empty, or when the current cycle is the last slot of a frame (the held pixel moves into the serializers on that cycle). While `pix_ready` is low, the source must keep the pixel and `pix_valid` unchanged. If nothing is held at a frame boundary, an all-zero frame is sent.

Top module: `lvds_tx7`

## Requirements
- R1: Each frame spans seven bit-clock cycles, with slot 0 sent first. Over slots 0 to 6 the lane clock is 1,1,0,0,0,1,1, and the mirror input does not change it.
- R2: Map code 0 (code 3 acts the same) is the 18-bit layout. Lane 0 slots 0..6 carry G[2], R[7], R[6], R[5], R[4], R[3], R[2]. Lane 1 carries B[3], B[2], G[7], G[6], G[5], G[4], G[3]. Lane 2 carries DE, VS, HS, B[7], B[6], B[5], B[4]. Lane 3 stays 0, and colour bits [1:0] have no effect.
- R3: Map code 2 sends the low six colour bits on lanes 0..2. Lane 0 carries G[0], R[5]..R[0]. Lane 1 carries B[1], B[0], G[5]..G[1]. Lane 2 carries DE, VS, HS, B[5]..B[2]. Lane 3 carries 0, B[7], B[6], G[7], G[6], R[7], R[6].
- R4: Map code 1 uses the R2 layout on lanes 0..2. Lane 3 carries 0, B[1], B[0], G[1], G[0], R[1], R[0].
- R5: The control slots are fixed in every map: lane 2 slot 0 is DE, slot 1 is VS, slot 2 is HS, and lane 3 slot 0 is constant 0.
- R6: With the mirror input high, every data lane sends slot 6 first and slot 0 last.
- R7: `pix_ready` is high when the holding register is empty or the frame is on its last slot. Accepted pixels go out in order, in back-to-back frames with no idle slot.
- R8: While a pixel is held and the frame is not on its last slot, `pix_ready` is low.
- R9: A frame that starts with no pixel held sends 0 on every data lane. The lane clock keeps its pattern.
- R10: An active-high synchronous reset drives all lanes and the lane clock to 0, holds `pix_ready` low and empties the holding register. Slot 0 of the first frame appears on the first cycle after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 7x bit clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_map | input | 2 | Slot layout: 0 = 18-bit, 1 = 24-bit upper-first, 2 = 24-bit lower-first, 3 = as 0 |
| cfg_mirror | input | 1 | Reverse slot order on the data lanes |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Pixel can be taken this cycle |
| pix_r | input | 8 | Red |
| pix_g | input | 8 | Green |
| pix_b | input | 8 | Blue |
| pix_hs | input | 1 | Horizontal sync |
| pix_vs | input | 1 | Vertical sync |
| pix_de | input | 1 | Data enable |
| lane_data | output | 4 | Data lane bits, one per lane |
| lane_clk | output | 1 | Lane clock bit |

## Verification
The assertions check the following on every cycle: the lane clock against the slot counter, the wrap of the slot counter, the ready rule against the holding state, lane 3 staying quiet in 18-bit mode, the zero control slot, and quiet lanes after reset. Only the bench's scenarios can show that each colour bit lands in the right slot under each map and mirror setting. The same holds for the order in which accepted pixels come out, and for the all-zero frames that follow starved input.

// File: rtl/lvds_pkg.sv
package lvds_pkg;
  localparam int CW      = 8;
  localparam int NSLOT   = 7;
  localparam int NLANE   = 4;
  localparam int SLOT_W  = $clog2(NSLOT);
  localparam logic [NSLOT-1:0] LANE_CLK_PAT = 7'b1100011;

  typedef enum logic [1:0] {
    MAP_N18 = 2'd0,
    MAP_UP24 = 2'd1,
    MAP_LO24 = 2'd2,
    MAP_ALT18 = 2'd3
  } map_e;

  typedef struct packed {
    logic [CW-1:0] r;
    logic [CW-1:0] g;
    logic [CW-1:0] b;
    logic          hs;
    logic          vs;
    logic          de;
  } pix_t;

  typedef logic [NSLOT-1:0] slot_word_t;
endpackage

// File: rtl/lvds_pix_hold.sv
module lvds_pix_hold
  import lvds_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  pix_t in_pix,
  input  logic take,
  output pix_t frame_pix,
  output logic full_o
);
  pix_t held_q;
  logic full_q;
  logic acc;

  assign in_ready  = !rst && (!full_q || take);
  assign acc       = in_valid && in_ready;
  assign frame_pix = full_q ? held_q : '0;
  assign full_o    = full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      held_q <= '0;
    end else begin
      if (acc) held_q <= in_pix;
      if (take)     full_q <= acc;
      else if (acc) full_q <= 1'b1;
    end
  end
endmodule

// File: rtl/lvds_slot_cnt.sv
module lvds_slot_cnt #(
  parameter int N = 7,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] slot,
  output logic         last
);
  localparam logic [W-1:0] TOP = W'(N - 1);
  logic [W-1:0] cnt_q;

  assign slot = cnt_q;
  assign last = (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= TOP;
    else if (last) cnt_q <= '0;
    else           cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/lvds_lane_map.sv
module lvds_lane_map
  import lvds_pkg::*;
(
  input  logic [1:0] map_sel,
  input  pix_t       px,
  output slot_word_t words [NLANE]
);
  // word bit k is the value sent in slot k
  slot_word_t up0, up1, ctlw, lo0, lo1, lo2, hi3, low3;

  always_comb begin
    up0  = {px.r[2], px.r[3], px.r[4], px.r[5], px.r[6], px.r[7], px.g[2]};
    up1  = {px.g[3], px.g[4], px.g[5], px.g[6], px.g[7], px.b[2], px.b[3]};
    ctlw = {px.b[4], px.b[5], px.b[6], px.b[7], px.hs, px.vs, px.de};
    lo0  = {px.r[0], px.r[1], px.r[2], px.r[3], px.r[4], px.r[5], px.g[0]};
    lo1  = {px.g[1], px.g[2], px.g[3], px.g[4], px.g[5], px.b[0], px.b[1]};
    lo2  = {px.b[2], px.b[3], px.b[4], px.b[5], px.hs, px.vs, px.de};
    hi3  = {px.r[6], px.r[7], px.g[6], px.g[7], px.b[6], px.b[7], 1'b0};
    low3 = {px.r[0], px.r[1], px.g[0], px.g[1], px.b[0], px.b[1], 1'b0};
    case (map_e'(map_sel))
      MAP_UP24: begin
        words[0] = up0; words[1] = up1; words[2] = ctlw; words[3] = low3;
      end
      MAP_LO24: begin
        words[0] = lo0; words[1] = lo1; words[2] = lo2;  words[3] = hi3;
      end
      default: begin
        words[0] = up0; words[1] = up1; words[2] = ctlw; words[3] = '0;
      end
    endcase
  end
endmodule

// File: rtl/lvds_lane_ser.sv
module lvds_lane_ser #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         mirror,
  input  logic [W-1:0] word,
  output logic         bit_o
);
  logic [W-1:0] sh_q;
  logic [W-1:0] rev;

  always_comb begin
    for (int i = 0; i < W; i++) rev[i] = word[W-1-i];
  end

  assign bit_o = sh_q[0];

  always_ff @(posedge clk) begin
    if (rst)       sh_q <= '0;
    else if (load) sh_q <= mirror ? rev : word;
    else           sh_q <= {1'b0, sh_q[W-1:1]};
  end
endmodule

// File: rtl/lvds_tx7.sv
module lvds_tx7
  import lvds_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cfg_map,
  input  logic          cfg_mirror,
  input  logic          pix_valid,
  output logic          pix_ready,
  input  logic [CW-1:0] pix_r,
  input  logic [CW-1:0] pix_g,
  input  logic [CW-1:0] pix_b,
  input  logic          pix_hs,
  input  logic          pix_vs,
  input  logic          pix_de,
  output logic [NLANE-1:0] lane_data,
  output logic          lane_clk
);
  pix_t              in_px, frame_px;
  logic              held_full;
  logic [SLOT_W-1:0] slot_q;
  logic              slot_last;
  slot_word_t        words [NLANE];

  assign in_px = '{r: pix_r, g: pix_g, b: pix_b, hs: pix_hs, vs: pix_vs, de: pix_de};

  lvds_pix_hold u_hold (
    .clk(clk), .rst(rst), .in_valid(pix_valid), .in_ready(pix_ready),
    .in_pix(in_px), .take(slot_last), .frame_pix(frame_px), .full_o(held_full)
  );

  lvds_slot_cnt #(.N(NSLOT)) u_cnt (
    .clk(clk), .rst(rst), .slot(slot_q), .last(slot_last)
  );

  lvds_lane_map u_map (
    .map_sel(cfg_map), .px(frame_px), .words(words)
  );

  for (genvar ln = 0; ln < NLANE; ln++) begin : g_lane
    lvds_lane_ser #(.W(NSLOT)) u_ser (
      .clk(clk), .rst(rst), .load(slot_last), .mirror(cfg_mirror),
      .word(words[ln]), .bit_o(lane_data[ln])
    );
  end

  lvds_lane_ser #(.W(NSLOT)) u_clk_ser (
    .clk(clk), .rst(rst), .load(slot_last), .mirror(1'b0),
    .word(LANE_CLK_PAT), .bit_o(lane_clk)
  );
endmodule

// File: rtl/lvds_tx7_chk.sv
module lvds_tx7_chk
  import lvds_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cfg_map,
  input logic              cfg_mirror,
  input logic              pix_ready,
  input logic [NLANE-1:0]  lane_data,
  input logic              lane_clk,
  input logic [SLOT_W-1:0] slot_q,
  input logic              held_full
);
  localparam logic [7:0] PAT8 = {1'b0, LANE_CLK_PAT};
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NSLOT - 1);

  a_r10_quiet_lanes: assert property (@(posedge clk)
    rst |=> (lane_data == '0 && lane_clk == 1'b0));

  a_r10_no_ready: assert property (@(posedge clk)
    rst |-> !pix_ready);

  a_r1_slot_bound: assert property (@(posedge clk) disable iff (rst)
    slot_q <= LAST);

  a_r7_slot_wrap: assert property (@(posedge clk) disable iff (rst)
    slot_q == LAST |=> slot_q == '0);

  a_r1_clk_pattern: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> lane_clk == PAT8[slot_q]);

  a_r8_backpressure: assert property (@(posedge clk) disable iff (rst)
    (held_full && slot_q != LAST) |-> !pix_ready);

  a_r7_ready_free: assert property (@(posedge clk) disable iff (rst)
    (!held_full || slot_q == LAST) |-> pix_ready);

  a_r2_lane3_quiet: assert property (@(posedge clk) disable iff (rst)
    (cfg_map == 2'd0 || cfg_map == 2'd3) |-> !lane_data[3]);

  a_r5_ctl3_zero: assert property (@(posedge clk) disable iff (rst)
    ((slot_q == '0 && !cfg_mirror) || (slot_q == LAST && cfg_mirror)) |-> !lane_data[3]);
endmodule

bind lvds_tx7 lvds_tx7_chk u_chk (
  .clk(clk), .rst(rst), .cfg_map(cfg_map), .cfg_mirror(cfg_mirror),
  .pix_ready(pix_ready), .lane_data(lane_data), .lane_clk(lane_clk),
  .slot_q(slot_q), .held_full(held_full)
);

// File: tb/sim_lvds_tx7.sv
module sim_lvds_tx7;
  import lvds_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  logic [1:0] cfg_map = 2'd0;
  logic       cfg_mirror = 1'b0;
  logic       drv_valid = 1'b0;
  pix_t       drv = '0;
  logic       pix_ready;
  logic [3:0] lane_data;
  logic       lane_clk;

  lvds_tx7 u0 (
    .clk(clk), .rst(rst), .cfg_map(cfg_map), .cfg_mirror(cfg_mirror),
    .pix_valid(drv_valid), .pix_ready(pix_ready),
    .pix_r(drv.r), .pix_g(drv.g), .pix_b(drv.b),
    .pix_hs(drv.hs), .pix_vs(drv.vs), .pix_de(drv.de),
    .lane_data(lane_data), .lane_clk(lane_clk)
  );

  int   n_chk = 0;
  int   n_fail = 0;
  int   pcnt = 0;
  bit   acc_last = 0;
  bit   done = 0;
  bit   exp_under = 1;
  pix_t exp_pix = '0;
  pix_t q[$];
  logic [6:0] got [5];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // expected bit for a lane and slot, from the layouts in the requirements
  function automatic logic exp_bit(input logic [1:0] m, input pix_t p,
                                   input int ln, input int s);
    logic [7:0] c;
    c = (s <= 2) ? p.b : (s <= 4) ? p.g : p.r;
    if (m == 2'd2) begin
      case (ln)
        0: return (s == 0) ? p.g[0] : p.r[6-s];
        1: return (s == 0) ? p.b[1] : (s == 1) ? p.b[0] : p.g[7-s];
        2: return (s == 0) ? p.de : (s == 1) ? p.vs : (s == 2) ? p.hs : p.b[8-s];
        default: return (s == 0) ? 1'b0 : c[(s % 2 == 1) ? 7 : 6];
      endcase
    end
    case (ln)
      0: return (s == 0) ? p.g[2] : p.r[8-s];
      1: return (s == 0) ? p.b[3] : (s == 1) ? p.b[2] : p.g[9-s];
      2: return (s == 0) ? p.de : (s == 1) ? p.vs : (s == 2) ? p.hs : p.b[10-s];
      default: return (m == 2'd1 && s != 0) ? c[(s % 2 == 1) ? 1 : 0] : 1'b0;
    endcase
  endfunction

  function automatic string map_tag(input logic [1:0] m);
    if (m == 2'd1) return "R4";
    if (m == 2'd2) return "R3";
    return "R2";
  endfunction

  task automatic compare_frame();
    logic [6:0] e;
    logic [3:0] ctl_got, ctl_exp;
    string tag;
    for (int ln = 0; ln < 4; ln++) begin
      for (int k = 0; k < 7; k++)
        e[k] = exp_bit(cfg_map, exp_pix, ln, cfg_mirror ? 6 - k : k);
      tag = exp_under ? "R9" : (cfg_mirror ? "R6" : map_tag(cfg_map));
      check(got[ln] == e, tag, $sformatf("lane %0d frame", ln), got[ln], e);
    end
    check(got[4] == 7'b1100011, "R1", "lane clock frame", got[4], 7'b1100011);
    // control slots: lane3 s0, lane2 s2, s1, s0
    ctl_got = cfg_mirror ? {got[3][6], got[2][4], got[2][5], got[2][6]}
                         : {got[3][0], got[2][2], got[2][1], got[2][0]};
    ctl_exp = {1'b0, exp_pix.hs, exp_pix.vs, exp_pix.de};
    check(ctl_got == ctl_exp, "R5", "control slots", ctl_got, ctl_exp);
  endtask

  // monitor: one sample per cycle, 1 ns before the rising edge
  initial forever begin
    @(negedge clk); #1;
    if (rst) begin
      pcnt = 0; q.delete(); acc_last = 0; exp_under = 1; exp_pix = '0;
    end else begin
      if (pcnt >= 1) begin
        int k;
        k = (pcnt - 1) % 7;
        for (int ln = 0; ln < 4; ln++) got[ln][k] = lane_data[ln];
        got[4][k] = lane_clk;
        if (pcnt == 1) check(lane_clk == 1'b1, "R10", "first slot after release", lane_clk, 1);
        if (k == 6) compare_frame();
      end
      if (q.size() != 0 && (pcnt % 7) != 0)
        check(pix_ready == 1'b0, "R8", "ready while held", pix_ready, 0);
      else
        check(pix_ready == 1'b1, "R7", "ready when free", pix_ready, 1);
      if ((pcnt % 7) == 0) begin
        if (q.size() != 0) begin exp_pix = q.pop_front(); exp_under = 0; end
        else begin exp_pix = '0; exp_under = 1; end
      end
      acc_last = drv_valid && pix_ready;
      if (acc_last) q.push_back(drv);
      pcnt++;
    end
  end

  task automatic do_reset(input logic [1:0] m, input logic mir);
    @(negedge clk);
    rst = 1'b1; drv_valid = 1'b0; cfg_map = m; cfg_mirror = mir;
    repeat (4) @(negedge clk);
    #1;
    check(lane_data == 4'h0 && lane_clk == 1'b0, "R10", "lanes in reset",
          {lane_clk, lane_data}, 0);
    check(pix_ready == 1'b0, "R10", "ready in reset", pix_ready, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_phase(input int cycles, input int vpct);
    repeat (cycles) begin
      @(negedge clk);
      if (!(drv_valid && !acc_last)) begin
        drv_valid = ($urandom % 100) < vpct;
        drv.r = 8'($urandom); drv.g = 8'($urandom); drv.b = 8'($urandom);
        drv.hs = 1'($urandom); drv.vs = 1'($urandom); drv.de = 1'($urandom);
      end
    end
  endtask

  task automatic idle_phase(input int cycles);
    repeat (cycles) begin
      @(negedge clk);
      if (!(drv_valid && !acc_last)) drv_valid = 1'b0;
    end
  endtask

  task automatic corner_phase();
    // all-ones and all-zero pixels back to back, held valid
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      drv_valid = 1'b1;
      drv = (i % 2 == 0) ? '1 : '0;
      @(negedge clk);
      while (!acc_last) @(negedge clk);
    end
    drv_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int m = 0; m < 4; m++) begin
      for (int mir = 0; mir < 2; mir++) begin
        do_reset(2'(m), 1'(mir));
        run_phase(280, 100);
        run_phase(280, 60);
        idle_phase(30);
        corner_phase();
        run_phase(140, 100);
      end
    end
    repeat (20) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule